// File: doc/BRIEF.md
# MAC Control Frame Classifier

This block sits beside an Ethernet receive parser and sorts each received frame into one of three classes: an ordinary frame, a frame dropped by the address filter, or a MAC control frame. The parser reports each header field as it decodes it, each with its own strobe: the length/type word, the address-filter hit, and the opcode with its operand. At the end of the frame the parser also supplies the total byte count (CRC included) and the CRC status. A start-of-frame strobe clears the fields held from the previous frame.

A control frame makes the block fire a pause request only when five conditions hold together: control type, address hit, exactly 64 bytes, good CRC and the pause opcode. The pause request carries the operand to the transmit-side pause timer. A control frame that fails the length, CRC or opcode test is still marked as a control frame, but nothing acts on it. A pass-through enable decides whether marked control frames go on to the host or are absorbed inside the MAC. A flow-control enable can mute the pause request without changing how frames are classified.

The verdict is a single-cycle result pulse with no ready input. The receive path cannot be stalled, so the consumer must accept the verdict in the cycle it appears. No back-pressure is defined. Plain control pins (the enables) are sampled in the end-of-frame cycle.

Top module: `mac_ctrl_classifier`

## Requirements
- R1: `res_vld_o` is high for exactly the one cycle that follows each cycle in which `eof_i` is sampled high, and is low at all other times, including right after reset.
- R2: Whenever `res_vld_o` is high, exactly one of `res_normal_o`, `res_reject_o` and `res_ctrl_o` is high. All of them are low when `res_vld_o` is low.
- R3: A frame with an address hit and a length/type value other than 16'h8808 is reported as normal. It gets `pass_host_o`=1 and no pause request.
- R4: A frame without an address hit is reported as rejected, whatever its type. It gets `pass_host_o`=0 and no pause request.
- R5: A frame with an address hit and length/type 16'h8808 is reported as a control frame (`res_ctrl_o`).
- R6: `pause_req_o` pulses together with `res_vld_o` only for a control frame that also has byte count 64, good CRC and opcode 16'h0001, with `fc_en_i` high. During that pulse `pause_quanta_o` equals the operand; otherwise it is 0.
- R7: A control frame whose byte count is not 64 (for example 63 or 65) is still reported as a control frame but makes no pause request.
- R8: A control frame with a bad CRC, or with an opcode other than 16'h0001 (or no opcode strobe), is still marked as control but makes no pause request.
- R9: For a control frame, `pass_host_o` equals `pass_en_i` sampled in the end-of-frame cycle.
- R10: With `fc_en_i` low, `pause_req_o` stays low, and control frames are still marked exactly as with it high.
- R11: A field strobe in the same cycle as `eof_i` is used for that frame's verdict. `sof_i` clears every held field, so a frame whose type or address strobe never comes is treated as having no control type and no address hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Start of frame, clears held fields |
| type_vld_i | input | 1 | Length/type field strobe |
| type_i | input | 16 | Length/type value |
| da_vld_i | input | 1 | Address-filter result strobe |
| da_hit_i | input | 1 | Destination address accepted |
| op_vld_i | input | 1 | Opcode/operand strobe |
| opcode_i | input | 16 | Control opcode |
| operand_i | input | 16 | Pause operand |
| eof_i | input | 1 | End of frame, verdict is taken |
| byte_cnt_i | input | 16 | Frame length in bytes incl. CRC, valid with eof_i |
| crc_ok_i | input | 1 | CRC good, valid with eof_i |
| fc_en_i | input | 1 | Flow-control enable |
| pass_en_i | input | 1 | Forward control frames to host |
| res_vld_o | output | 1 | Verdict pulse |
| res_normal_o | output | 1 | Ordinary frame |
| res_reject_o | output | 1 | Address-filter reject |
| res_ctrl_o | output | 1 | MAC control frame |
| pass_host_o | output | 1 | Frame goes to host |
| pause_req_o | output | 1 | Pause request pulse |
| pause_quanta_o | output | 16 | Pause operand with the request |

## Verification
Two events can land in the same cycle: the opcode strobe (or the type or address strobe) and the end-of-frame strobe. The verdict must then use the value arriving in that cycle, not the stale held copy. The bench provokes this by sending a pause frame whose opcode strobe lines up with `eof_i`. In the cycle before, it drives a non-pause opcode, so that reading the stale copy would miss the pause. The result is judged against the expected pause pulse and operand. A second case starts a frame whose type strobe never arrives, to show that `sof_i` has cleared the previous frame's control type.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  typedef struct packed {
    logic is_normal;
    logic is_reject;
    logic is_ctrl;
    logic pause;
    logic pass_host;
  } verdict_t;
endpackage

// File: rtl/mcc_field_hold.sv
module mcc_field_hold #(
  parameter int TYPE_W = 16,
  parameter int OP_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_i,
  input  logic              type_vld_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic              da_vld_i,
  input  logic              da_hit_i,
  input  logic              op_vld_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [OP_W-1:0]   operand_i,
  output logic              eff_type_seen_o,
  output logic [TYPE_W-1:0] eff_type_o,
  output logic              eff_da_hit_o,
  output logic              eff_op_seen_o,
  output logic [OP_W-1:0]   eff_opcode_o,
  output logic [OP_W-1:0]   eff_operand_o
);
  logic              type_seen_q, da_hit_q, op_seen_q;
  logic [TYPE_W-1:0] type_q;
  logic [OP_W-1:0]   opcode_q, operand_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      type_seen_q <= 1'b0;
      da_hit_q    <= 1'b0;
      op_seen_q   <= 1'b0;
      type_q      <= '0;
      opcode_q    <= '0;
      operand_q   <= '0;
    end else begin
      if (sof_i) begin
        type_seen_q <= 1'b0;
        da_hit_q    <= 1'b0;
        op_seen_q   <= 1'b0;
      end
      if (type_vld_i) begin
        type_seen_q <= 1'b1;
        type_q      <= type_i;
      end
      if (da_vld_i) da_hit_q <= da_hit_i;
      if (op_vld_i) begin
        op_seen_q <= 1'b1;
        opcode_q  <= opcode_i;
        operand_q <= operand_i;
      end
    end
  end

  // Same-cycle bypass: a strobe arriving with end of frame still counts
  always_comb begin
    eff_type_seen_o = type_vld_i | type_seen_q;
    eff_type_o      = type_vld_i ? type_i : type_q;
    eff_da_hit_o    = da_vld_i ? da_hit_i : da_hit_q;
    eff_op_seen_o   = op_vld_i | op_seen_q;
    eff_opcode_o    = op_vld_i ? opcode_i : opcode_q;
    eff_operand_o   = op_vld_i ? operand_i : operand_q;
  end
endmodule

// File: rtl/mcc_judge.sv
module mcc_judge
  import mcc_pkg::*;
#(
  parameter int              TYPE_W    = 16,
  parameter int              OP_W      = 16,
  parameter int              LEN_W     = 16,
  parameter logic [TYPE_W-1:0] CTRL_TYPE = 16'h8808,
  parameter logic [OP_W-1:0]   PAUSE_OP  = 16'h0001,
  parameter int              CTRL_LEN  = 64
) (
  input  logic              type_seen_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic              da_hit_i,
  input  logic              op_seen_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [LEN_W-1:0]  byte_cnt_i,
  input  logic              crc_ok_i,
  input  logic              fc_en_i,
  input  logic              pass_en_i,
  output verdict_t          verdict_o
);
  localparam logic [LEN_W-1:0] LEN_EXACT = LEN_W'(CTRL_LEN);

  logic ctrl_type, len_ok, op_ok, act_ok;

  always_comb begin
    ctrl_type = type_seen_i && (type_i == CTRL_TYPE);
    len_ok    = (byte_cnt_i == LEN_EXACT);
    op_ok     = op_seen_i && (opcode_i == PAUSE_OP);
    act_ok    = len_ok && crc_ok_i && op_ok;

    verdict_o.is_reject = !da_hit_i;
    verdict_o.is_normal = da_hit_i && !ctrl_type;
    verdict_o.is_ctrl   = da_hit_i && ctrl_type;
    verdict_o.pause     = verdict_o.is_ctrl && act_ok && fc_en_i;
    verdict_o.pass_host = verdict_o.is_normal || (verdict_o.is_ctrl && pass_en_i);
  end
endmodule

// File: rtl/mcc_result_reg.sv
module mcc_result_reg
  import mcc_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eof_i,
  input  verdict_t        verdict_i,
  input  logic [OP_W-1:0] operand_i,
  output logic            res_vld_o,
  output verdict_t        verdict_o,
  output logic [OP_W-1:0] quanta_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld_o <= 1'b0;
      verdict_o <= '0;
      quanta_o  <= '0;
    end else begin
      res_vld_o <= eof_i;
      verdict_o <= eof_i ? verdict_i : '0;
      quanta_o  <= (eof_i && verdict_i.pause) ? operand_i : '0;
    end
  end

  // R2: exactly one class flag per verdict
  p_one_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> $countones({verdict_o.is_normal, verdict_o.is_reject, verdict_o.is_ctrl}) == 1);
  // R2: no flags outside the verdict pulse
  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld_o |-> (verdict_o == '0 && quanta_o == '0));
  // R4: a reject is never forwarded nor paused
  p_reject_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_o.is_reject |-> (!verdict_o.pass_host && !verdict_o.pause));
  // R6: pause only with a control verdict
  p_pause_is_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_o.pause |-> (res_vld_o && verdict_o.is_ctrl));
endmodule

// File: rtl/mac_ctrl_classifier.sv
module mac_ctrl_classifier
  import mcc_pkg::*;
#(
  parameter int                TYPE_W    = 16,
  parameter int                OP_W      = 16,
  parameter int                LEN_W     = 16,
  parameter logic [TYPE_W-1:0] CTRL_TYPE = 16'h8808,
  parameter logic [OP_W-1:0]   PAUSE_OP  = 16'h0001,
  parameter int                CTRL_LEN  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_i,
  input  logic              type_vld_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic              da_vld_i,
  input  logic              da_hit_i,
  input  logic              op_vld_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [OP_W-1:0]   operand_i,
  input  logic              eof_i,
  input  logic [LEN_W-1:0]  byte_cnt_i,
  input  logic              crc_ok_i,
  input  logic              fc_en_i,
  input  logic              pass_en_i,
  output logic              res_vld_o,
  output logic              res_normal_o,
  output logic              res_reject_o,
  output logic              res_ctrl_o,
  output logic              pass_host_o,
  output logic              pause_req_o,
  output logic [OP_W-1:0]   pause_quanta_o
);
  logic              f_type_seen, f_da_hit, f_op_seen;
  logic [TYPE_W-1:0] f_type;
  logic [OP_W-1:0]   f_opcode, f_operand;
  verdict_t          comb_v, reg_v;

  mcc_field_hold #(.TYPE_W(TYPE_W), .OP_W(OP_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i),
    .type_vld_i(type_vld_i), .type_i(type_i),
    .da_vld_i(da_vld_i), .da_hit_i(da_hit_i),
    .op_vld_i(op_vld_i), .opcode_i(opcode_i), .operand_i(operand_i),
    .eff_type_seen_o(f_type_seen), .eff_type_o(f_type),
    .eff_da_hit_o(f_da_hit), .eff_op_seen_o(f_op_seen),
    .eff_opcode_o(f_opcode), .eff_operand_o(f_operand)
  );

  mcc_judge #(
    .TYPE_W(TYPE_W), .OP_W(OP_W), .LEN_W(LEN_W),
    .CTRL_TYPE(CTRL_TYPE), .PAUSE_OP(PAUSE_OP), .CTRL_LEN(CTRL_LEN)
  ) u_judge (
    .type_seen_i(f_type_seen), .type_i(f_type), .da_hit_i(f_da_hit),
    .op_seen_i(f_op_seen), .opcode_i(f_opcode),
    .byte_cnt_i(byte_cnt_i), .crc_ok_i(crc_ok_i),
    .fc_en_i(fc_en_i), .pass_en_i(pass_en_i),
    .verdict_o(comb_v)
  );

  mcc_result_reg #(.OP_W(OP_W)) u_res (
    .clk(clk), .rst_n(rst_n), .eof_i(eof_i),
    .verdict_i(comb_v), .operand_i(f_operand),
    .res_vld_o(res_vld_o), .verdict_o(reg_v), .quanta_o(pause_quanta_o)
  );

  assign res_normal_o = reg_v.is_normal;
  assign res_reject_o = reg_v.is_reject;
  assign res_ctrl_o   = reg_v.is_ctrl;
  assign pass_host_o  = reg_v.pass_host;
  assign pause_req_o  = reg_v.pause;

  // R1: end of frame yields a verdict next cycle
  p_eof_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
    eof_i |=> res_vld_o);
  // R1: no verdict without an end of frame
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !eof_i |=> !res_vld_o);
  // R10: flow control off mutes the pause request
  p_fc_off_mute_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_i && !fc_en_i) |=> !pause_req_o);
  // R9: control frames follow the pass-through enable
  p_ctrl_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && res_ctrl_o) |-> (pass_host_o == $past(pass_en_i)));
  // R7: a wrong length never pauses
  p_len_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_i && byte_cnt_i != LEN_W'(CTRL_LEN)) |=> !pause_req_o);
endmodule

// File: tb/mac_ctrl_classifier_bench.sv
module mac_ctrl_classifier_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof_i = 0, type_vld_i = 0, da_vld_i = 0, da_hit_i = 0, op_vld_i = 0;
  logic eof_i = 0, crc_ok_i = 0, fc_en_i = 1, pass_en_i = 0;
  logic [15:0] type_i = '0, opcode_i = '0, operand_i = '0, byte_cnt_i = '0;
  logic res_vld_o, res_normal_o, res_reject_o, res_ctrl_o, pass_host_o, pause_req_o;
  logic [15:0] pause_quanta_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  mac_ctrl_classifier u_mac_ctrl_classifier (.*);

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Sends one frame; checks the verdict one cycle after eof, then idle
  task automatic frame(input string req, input logic [15:0] ty, input logic send_ty,
                       input logic hit, input logic send_op, input logic [15:0] op,
                       input logic [15:0] arg, input logic [15:0] len, input logic crc,
                       input logic op_at_eof);
    logic ctrl, normal, reject, pause, pass;
    reject = !hit;
    ctrl   = hit && send_ty && (ty == 16'h8808);
    normal = hit && !ctrl;
    pause  = ctrl && send_op && op == 16'h0001 && len == 16'd64 && crc && fc_en_i;
    pass   = normal || (ctrl && pass_en_i);
    sof_i = 1; tick(); sof_i = 0;
    if (send_ty) begin type_vld_i = 1; type_i = ty; tick(); type_vld_i = 0; end
    da_vld_i = 1; da_hit_i = hit; tick(); da_vld_i = 0;
    if (send_op && !op_at_eof) begin
      op_vld_i = 1; opcode_i = op; operand_i = arg; tick(); op_vld_i = 0;
    end
    if (send_op && op_at_eof) begin
      // stale held opcode differs, so only the same-cycle value can pause
      op_vld_i = 1; opcode_i = 16'h0005; operand_i = 16'hDEAD; tick();
      opcode_i = op; operand_i = arg;
    end
    eof_i = 1; byte_cnt_i = len; crc_ok_i = crc;
    tick();
    eof_i = 0; op_vld_i = 0;
    chk({req, " vld (R1)"}, {31'd0, res_vld_o}, 32'd1);
    chk({req, " class (R2)"}, {29'd0, res_normal_o, res_reject_o, res_ctrl_o},
        {29'd0, normal, reject, ctrl});
    chk({req, " pass"}, {31'd0, pass_host_o}, {31'd0, pass});
    chk({req, " pause"}, {15'd0, pause_req_o, pause_quanta_o},
        {15'd0, pause, pause ? arg : 16'd0});
    tick();
    chk({req, " pulse ends (R1)"}, {27'd0, res_vld_o, res_normal_o, res_reject_o,
        res_ctrl_o, pause_req_o}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 reset", {26'd0, res_vld_o, res_normal_o, res_reject_o, res_ctrl_o,
        pass_host_o, pause_req_o}, 32'd0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    frame("R3 normal ip",  16'h0800, 1, 1, 0, 16'h0, 16'h0, 16'd64, 1, 0);
    frame("R4 reject ctrl",16'h8808, 1, 0, 1, 16'h0001, 16'h0100, 16'd64, 1, 0);
    frame("R4 reject norm",16'h0806, 1, 0, 0, 16'h0, 16'h0, 16'd100, 1, 0);
    frame("R5 R6 pause",   16'h8808, 1, 1, 1, 16'h0001, 16'h1234, 16'd64, 1, 0);
    frame("R7 len63",      16'h8808, 1, 1, 1, 16'h0001, 16'h0055, 16'd63, 1, 0);
    frame("R7 len65",      16'h8808, 1, 1, 1, 16'h0001, 16'h0055, 16'd65, 1, 0);
    frame("R8 bad crc",    16'h8808, 1, 1, 1, 16'h0001, 16'h0077, 16'd64, 0, 0);
    frame("R8 bad op",     16'h8808, 1, 1, 1, 16'h0002, 16'h0077, 16'd64, 1, 0);
    frame("R8 no op",      16'h8808, 1, 1, 0, 16'h0000, 16'h0000, 16'd64, 1, 0);
    pass_en_i = 1;
    frame("R9 pass on",    16'h8808, 1, 1, 1, 16'h0001, 16'hFFFF, 16'd64, 1, 0);
    frame("R9 pass ctrl",  16'h8808, 1, 1, 1, 16'h0003, 16'h0001, 16'd64, 1, 0);
    fc_en_i = 0;
    frame("R10 fc off",    16'h8808, 1, 1, 1, 16'h0001, 16'h0200, 16'd64, 1, 0);
    fc_en_i = 1; pass_en_i = 0;
    frame("R11 op at eof", 16'h8808, 1, 1, 1, 16'h0001, 16'h4321, 16'd64, 1, 1);
    frame("R11 no type",   16'h8808, 0, 1, 1, 16'h0001, 16'h0009, 16'd64, 1, 0);
    repeat (3) tick();
    chk("R1 idle", {31'd0, res_vld_o}, 32'd0);
    summary();
  end
endmodule